// File: doc/BRIEF.md
# Remappable Peripheral Pin Crossbar

This block sits between a bank of general purpose pins and the digital peripherals of a chip. It lets software choose which pin feeds each peripheral input and which peripheral output drives each pin. The two directions are configured separately. Each peripheral input owns a select field that names the pin it listens to. Each pin owns a function code that names the peripheral output allowed to drive it. Code zero leaves the pin with the general purpose port, which supplies the latch value and the direction bit.

Configuration lives in 16-bit registers that hold two 6-bit fields each. One register bank holds the input selects and a second bank holds the pin function codes. Register writes take effect on the next clock edge. The routing itself is purely combinational, so a pin level or a peripheral output reaches its destination in the same cycle.

A per-pin analog mask takes a pin away from the digital logic. While a pin is in analog mode, its digital reading is zero and nothing drives it.

Top module: `pin_xbar`

## Requirements
- R1: Each peripheral input k equals the digital level of the pin whose number is held in its 6-bit input select field. The level comes from that pin's input gated by its analog mask bit. It changes in the same cycle as the pin.
- R2: After reset every input select field holds 63. With the default pin count this means every peripheral input reads 0, whatever the pin levels are.
- R3: An input select value greater than or equal to NUM_PINS ties that peripheral input to 0.
- R4: After reset every pin function code is 0. With code 0, pin_out equals the GPIO latch bit and pin_oe equals the inverse of the GPIO direction bit, where direction 1 means input.
- R5: A pin with function code c, where 1 <= c <= NUM_CODES-1, drives pin_out from func_out_data[c] and pin_oe from func_out_en[c].
- R6: Function codes from NUM_CODES to 63 are treated exactly like code 0.
- R7: Register layout.
  - Address bit 5 selects the bank: 0 is the input selects, 1 is the pin codes.
  - Address bits 4:0 give a register index r.
  - Register r holds the field of item 2r in bits 5:0 and the field of item 2r+1 in bits 13:8.
  - Bits 15:14 and 7:6 read 0.
  - Fields of inputs or pins that do not exist read 0, and writes to them have no effect.
  - A write is visible on the read port and in the routing from the cycle after the write edge.
- R8: Mappings have no mutual exclusion. Several peripheral inputs may select the same pin, and several pins may carry the same function code. Every one of them is routed.
- R9: A pin whose analog mask bit is 1 has pin_rdval = 0, pin_out = 0 and pin_oe = 0. It also feeds 0 to every peripheral input that selects it.
- R10: pin_rdval equals pin_in for every pin whose analog mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 6 | Write address: bank bit 5, index bits 4:0 |
| cfg_wdata | input | 16 | Write data (two 6-bit fields) |
| cfg_raddr | input | 6 | Read address |
| cfg_rdata | output | 16 | Read data, combinational |
| pin_in | input | NUM_PINS | Levels sampled from the pins |
| pin_analog | input | NUM_PINS | Analog mode mask, 1 = analog |
| gpio_lat | input | NUM_PINS | GPIO output latch bits |
| gpio_dir | input | NUM_PINS | GPIO direction bits, 1 = input |
| func_out_data | input | NUM_CODES-1 | Peripheral output data, bit c for code c (bits NUM_CODES-1:1) |
| func_out_en | input | NUM_CODES-1 | Peripheral output enables, bit c for code c |
| pin_out | output | NUM_PINS | Resolved pin output data |
| pin_oe | output | NUM_PINS | Resolved pin output enable |
| pin_rdval | output | NUM_PINS | Digital read value per pin |
| periph_in | output | NUM_INPUTS | Routed peripheral input levels |

## Verification
Several properties are checked every cycle against the stored fields:
- an out-of-range input select produces a low input;
- an analog pin is silent and reads 0;
- a null or reserved function code hands the pin to the GPIO latch and direction;
- a register write lands in the addressed field one cycle later;
- all peripheral inputs are low straight after reset.

The bench's scenarios are the only place where the following can be shown:
- the register packing and zero padding seen through the read port;
- the ignored fields beyond the last input;
- the fan-out cases;
- the exact routing of every implemented function code.

The bench compares these against its own model of the register file.

// File: rtl/pxb_pkg.sv
package pxb_pkg;

    localparam int SEL_W  = 6;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 6;
    localparam int IDX_W  = ADDR_W - 1;
    localparam int EXT_W  = 1 << SEL_W;

    localparam logic [SEL_W-1:0] IN_SEL_RESET = '1;
    localparam logic [SEL_W-1:0] OUT_NULL     = '0;

    typedef enum logic {
        BANK_IN  = 1'b0,
        BANK_OUT = 1'b1
    } bank_e;

    typedef struct packed {
        bank_e            bank;
        logic [IDX_W-1:0] idx;
    } reg_addr_t;

    typedef struct packed {
        logic data;
        logic oe;
    } pin_drive_t;

    // Bit offset of a field inside its register (even item low, odd item high)
    function automatic int field_lsb(int item);
        return (item % 2) * 8;
    endfunction

    // Build a register image from the two fields it carries
    function automatic logic [REG_W-1:0] pair_word(logic [SEL_W-1:0] lo,
                                                   logic [SEL_W-1:0] hi);
        return {2'b00, hi, 2'b00, lo};
    endfunction

endpackage

// File: rtl/pxb_cfg_regs.sv
module pxb_cfg_regs
    import pxb_pkg::*;
#(
    parameter int NUM_INPUTS = 11,
    parameter int NUM_PINS   = 10
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               we,
    input  logic [ADDR_W-1:0]                  waddr,
    input  logic [REG_W-1:0]                   wdata,
    input  logic [ADDR_W-1:0]                  raddr,
    output logic [REG_W-1:0]                   rdata,
    output logic [NUM_INPUTS-1:0][SEL_W-1:0]   in_sel,
    output logic [NUM_PINS-1:0][SEL_W-1:0]     out_code
);

    localparam int IN_REGS  = (NUM_INPUTS + 1) / 2;
    localparam int OUT_REGS = (NUM_PINS + 1) / 2;

    reg_addr_t wa;
    reg_addr_t ra;
    assign wa = reg_addr_t'(waddr);
    assign ra = reg_addr_t'(raddr);

    logic unused_wbits;
    assign unused_wbits = ^{wdata[15:14], wdata[7:6]};

    // Input select storage, one field per peripheral input
    for (genvar k = 0; k < NUM_INPUTS; k++) begin : g_in_field
        logic [SEL_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= IN_SEL_RESET;
            else if (we && wa.bank == BANK_IN && wa.idx == IDX_W'(k / 2))
                q <= wdata[field_lsb(k) +: SEL_W];
        end
        assign in_sel[k] = q;
    end

    // Output function storage, one field per pin
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_out_field
        logic [SEL_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= OUT_NULL;
            else if (we && wa.bank == BANK_OUT && wa.idx == IDX_W'(p / 2))
                q <= wdata[field_lsb(p) +: SEL_W];
        end
        assign out_code[p] = q;
    end

    // Register images for reading; missing odd fields read as zero
    logic [REG_W-1:0] in_word  [IN_REGS];
    logic [REG_W-1:0] out_word [OUT_REGS];

    for (genvar r = 0; r < IN_REGS; r++) begin : g_in_word
        if (2 * r + 1 < NUM_INPUTS) begin : g_full
            assign in_word[r] = pair_word(in_sel[2*r], in_sel[2*r+1]);
        end else begin : g_half
            assign in_word[r] = pair_word(in_sel[2*r], '0);
        end
    end

    for (genvar r = 0; r < OUT_REGS; r++) begin : g_out_word
        if (2 * r + 1 < NUM_PINS) begin : g_full
            assign out_word[r] = pair_word(out_code[2*r], out_code[2*r+1]);
        end else begin : g_half
            assign out_word[r] = pair_word(out_code[2*r], '0);
        end
    end

    always_comb begin
        rdata = '0;
        if (ra.bank == BANK_IN) begin
            for (int r = 0; r < IN_REGS; r++)
                if (ra.idx == IDX_W'(r)) rdata = in_word[r];
        end else begin
            for (int r = 0; r < OUT_REGS; r++)
                if (ra.idx == IDX_W'(r)) rdata = out_word[r];
        end
    end

endmodule

// File: rtl/pxb_in_route.sv
module pxb_in_route
    import pxb_pkg::*;
#(
    parameter int NUM_INPUTS = 11,
    parameter int NUM_PINS   = 10
) (
    input  logic [NUM_PINS-1:0]              pin_digital,
    input  logic [NUM_INPUTS-1:0][SEL_W-1:0] in_sel,
    output logic [NUM_INPUTS-1:0]            periph_in
);

    // Pins beyond the implemented count appear as constant zero
    logic [EXT_W-1:0] din_ext;
    assign din_ext = EXT_W'(pin_digital);

    for (genvar k = 0; k < NUM_INPUTS; k++) begin : g_mux
        always_comb begin
            if (32'(in_sel[k]) < NUM_PINS)
                periph_in[k] = din_ext[in_sel[k]];
            else
                periph_in[k] = 1'b0;
        end
    end

endmodule

// File: rtl/pxb_out_route.sv
module pxb_out_route
    import pxb_pkg::*;
#(
    parameter int NUM_PINS  = 10,
    parameter int NUM_CODES = 24
) (
    input  logic [NUM_PINS-1:0][SEL_W-1:0] out_code,
    input  logic [NUM_PINS-1:0]            pin_analog,
    input  logic [NUM_PINS-1:0]            gpio_lat,
    input  logic [NUM_PINS-1:0]            gpio_dir,
    input  logic [NUM_CODES-1:1]           func_out_data,
    input  logic [NUM_CODES-1:1]           func_out_en,
    output logic [NUM_PINS-1:0]            pin_out,
    output logic [NUM_PINS-1:0]            pin_oe
);

    // Code 0 slot is a placeholder; it is never selected
    logic [EXT_W-1:0] data_ext;
    logic [EXT_W-1:0] en_ext;
    assign data_ext = EXT_W'({func_out_data, 1'b0});
    assign en_ext   = EXT_W'({func_out_en, 1'b0});

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pin_drive_t drv;
        always_comb begin
            if (pin_analog[p])
                drv = '{data: 1'b0, oe: 1'b0};
            else if (out_code[p] == OUT_NULL || 32'(out_code[p]) >= NUM_CODES)
                drv = '{data: gpio_lat[p], oe: ~gpio_dir[p]};
            else
                drv = '{data: data_ext[out_code[p]], oe: en_ext[out_code[p]]};
        end
        assign pin_out[p] = drv.data;
        assign pin_oe[p]  = drv.oe;
    end

endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
    import pxb_pkg::*;
#(
    parameter int NUM_PINS   = 10,
    parameter int NUM_INPUTS = 11,
    parameter int NUM_CODES  = 24
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [5:0]            cfg_waddr,
    input  logic [15:0]           cfg_wdata,
    input  logic [5:0]            cfg_raddr,
    output logic [15:0]           cfg_rdata,
    input  logic [NUM_PINS-1:0]   pin_in,
    input  logic [NUM_PINS-1:0]   pin_analog,
    input  logic [NUM_PINS-1:0]   gpio_lat,
    input  logic [NUM_PINS-1:0]   gpio_dir,
    input  logic [NUM_CODES-1:1]  func_out_data,
    input  logic [NUM_CODES-1:1]  func_out_en,
    output logic [NUM_PINS-1:0]   pin_out,
    output logic [NUM_PINS-1:0]   pin_oe,
    output logic [NUM_PINS-1:0]   pin_rdval,
    output logic [NUM_INPUTS-1:0] periph_in
);

    logic [NUM_INPUTS-1:0][SEL_W-1:0] in_sel;
    logic [NUM_PINS-1:0][SEL_W-1:0]   out_code;

    // Analog pins read zero on the digital side (R9, R10)
    assign pin_rdval = pin_in & ~pin_analog;

    pxb_cfg_regs #(
        .NUM_INPUTS (NUM_INPUTS),
        .NUM_PINS   (NUM_PINS)
    ) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .waddr    (cfg_waddr),
        .wdata    (cfg_wdata),
        .raddr    (cfg_raddr),
        .rdata    (cfg_rdata),
        .in_sel   (in_sel),
        .out_code (out_code)
    );

    pxb_in_route #(
        .NUM_INPUTS (NUM_INPUTS),
        .NUM_PINS   (NUM_PINS)
    ) u_in (
        .pin_digital (pin_rdval),
        .in_sel      (in_sel),
        .periph_in   (periph_in)
    );

    pxb_out_route #(
        .NUM_PINS  (NUM_PINS),
        .NUM_CODES (NUM_CODES)
    ) u_out (
        .out_code      (out_code),
        .pin_analog    (pin_analog),
        .gpio_lat      (gpio_lat),
        .gpio_dir      (gpio_dir),
        .func_out_data (func_out_data),
        .func_out_en   (func_out_en),
        .pin_out       (pin_out),
        .pin_oe        (pin_oe)
    );

    // ---------------- assertions ----------------
    p_reset_inputs_low_r2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (NUM_PINS >= 63 || periph_in == '0));

    for (genvar k = 0; k < NUM_INPUTS; k++) begin : g_in_chk
        p_oor_select_low_r3: assert property (@(posedge clk) disable iff (rst)
            (32'(in_sel[k]) >= NUM_PINS) |-> !periph_in[k]);
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin_chk
        p_analog_silent_r9: assert property (@(posedge clk) disable iff (rst)
            pin_analog[p] |-> (!pin_oe[p] && !pin_out[p] && !pin_rdval[p]));

        p_null_gpio_r4: assert property (@(posedge clk) disable iff (rst)
            (!pin_analog[p] && out_code[p] == '0)
            |-> (pin_oe[p] == !gpio_dir[p] && pin_out[p] == gpio_lat[p]));

        p_reserved_as_null_r6: assert property (@(posedge clk) disable iff (rst)
            (!pin_analog[p] && 32'(out_code[p]) >= NUM_CODES)
            |-> (pin_oe[p] == !gpio_dir[p] && pin_out[p] == gpio_lat[p]));

        p_code_write_lands_r7: assert property (@(posedge clk) disable iff (rst)
            (cfg_we && cfg_waddr == {1'b1, 5'(p / 2)})
            |=> out_code[p] == $past(cfg_wdata[(p % 2) * 8 +: SEL_W]));
    end

endmodule

// File: tb/pin_xbar_tb.sv
module pin_xbar_tb;

    localparam int NP = 10;
    localparam int NI = 11;
    localparam int NC = 24;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_we;
    logic [5:0]    cfg_waddr;
    logic [15:0]   cfg_wdata;
    logic [5:0]    cfg_raddr;
    logic [15:0]   cfg_rdata;
    logic [NP-1:0] pin_in, pin_analog, gpio_lat, gpio_dir;
    logic [NC-1:1] f_data, f_en;
    logic [NP-1:0] pin_out, pin_oe, pin_rdval;
    logic [NI-1:0] periph_in;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int m_in  [NI];
    int m_out [NP];

    always #5 clk = ~clk;

    pin_xbar #(.NUM_PINS(NP), .NUM_INPUTS(NI), .NUM_CODES(NC)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
        .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .pin_in(pin_in), .pin_analog(pin_analog), .gpio_lat(gpio_lat),
        .gpio_dir(gpio_dir), .func_out_data(f_data), .func_out_en(f_en),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_rdval(pin_rdval),
        .periph_in(periph_in)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_read(logic [5:0] a);
        logic [15:0] w = '0;
        int base = 2 * int'(a[4:0]);
        if (!a[5]) begin
            if (base < NI)     w[5:0]  = 6'(m_in[base]);
            if (base + 1 < NI) w[13:8] = 6'(m_in[base+1]);
        end else begin
            if (base < NP)     w[5:0]  = 6'(m_out[base]);
            if (base + 1 < NP) w[13:8] = 6'(m_out[base+1]);
        end
        return w;
    endfunction

    function automatic void model_write(logic [5:0] a, logic [15:0] d);
        int base = 2 * int'(a[4:0]);
        if (!a[5]) begin
            if (base < NI)     m_in[base]   = int'(d[5:0]);
            if (base + 1 < NI) m_in[base+1] = int'(d[13:8]);
        end else begin
            if (base < NP)     m_out[base]   = int'(d[5:0]);
            if (base + 1 < NP) m_out[base+1] = int'(d[13:8]);
        end
    endfunction

    function automatic logic [NI-1:0] exp_periph();
        logic [NI-1:0] v = '0;
        for (int k = 0; k < NI; k++)
            if (m_in[k] < NP) v[k] = pin_in[m_in[k]] & ~pin_analog[m_in[k]];
        return v;
    endfunction

    function automatic logic [2*NP-1:0] exp_drive();
        logic [NP-1:0] d = '0;
        logic [NP-1:0] e = '0;
        for (int p = 0; p < NP; p++) begin
            if (pin_analog[p]) begin
                d[p] = 1'b0; e[p] = 1'b0;
            end else if (m_out[p] == 0 || m_out[p] >= NC) begin
                d[p] = gpio_lat[p]; e[p] = ~gpio_dir[p];
            end else begin
                d[p] = f_data[m_out[p]]; e[p] = f_en[m_out[p]];
            end
        end
        return {e, d};
    endfunction

    task automatic cfg_write(logic [5:0] a, logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic check_all(string req);
        logic [2*NP-1:0] ed;
        #1;
        ed = exp_drive();
        check({req, " periph_in"}, 64'(periph_in), 64'(exp_periph()));
        check({req, " pin_out"},   64'(pin_out),   64'(ed[NP-1:0]));
        check({req, " pin_oe"},    64'(pin_oe),    64'(ed[2*NP-1:NP]));
        check({req, " pin_rdval"}, 64'(pin_rdval), 64'(pin_in & ~pin_analog));
    endtask

    task automatic check_read(string req, logic [5:0] a);
        cfg_raddr = a;
        #1;
        check(req, 64'(cfg_rdata), 64'(model_read(a)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; cfg_we = 1'b0; cfg_waddr = '0; cfg_wdata = '0; cfg_raddr = '0;
        pin_in = '1; pin_analog = '0; gpio_lat = 10'h2A5; gpio_dir = 10'h0F0;
        f_data = '1; f_en = '1;
        for (int k = 0; k < NI; k++) m_in[k] = 63;
        for (int p = 0; p < NP; p++) m_out[p] = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R2, R4: reset state
        check_all("R2 R4 reset");
        check("R2 periph low after reset", 64'(periph_in), 64'h0);
        check_read("R2 R7 in reg0 reset", 6'h00);
        cfg_raddr = 6'h00; #1;
        check("R2 in reg0 value", 64'(cfg_rdata), 64'h3F3F);
        cfg_raddr = 6'h05; #1;
        check("R7 half register pads", 64'(cfg_rdata), 64'h003F);
        cfg_raddr = 6'h21; #1;
        check("R4 out reg reset", 64'(cfg_rdata), 64'h0000);

        // R7: reserved bits read zero, missing field ignored
        cfg_write(6'h00, 16'hFFC1);
        cfg_raddr = 6'h00; #1;
        check("R7 pad bits zero", 64'(cfg_rdata), 64'h3F01);
        cfg_write(6'h05, 16'h0203);
        cfg_raddr = 6'h05; #1;
        check("R7 missing field ignored", 64'(cfg_rdata), 64'h0003);
        cfg_write(6'h14, 16'h1234);
        cfg_raddr = 6'h14; #1;
        check("R7 unimplemented register", 64'(cfg_rdata), 64'h0000);

        // R1, R3: last pin valid, first out of range ties low
        cfg_write(6'h01, 16'h0A09);
        pin_in = 10'h200; #1;
        check("R1 last pin routed", 64'(periph_in[2]), 64'h1);
        check("R3 select past last pin", 64'(periph_in[3]), 64'h0);
        check_all("R1 R3");

        // R8: one pin to several inputs, one code to several pins
        cfg_write(6'h02, 16'h0404);
        cfg_write(6'h03, 16'h0404);
        pin_in = 10'h010; #1;
        check("R8 pin fan-out", 64'(periph_in[7:4]), 64'hF);
        pin_in = 10'h3EF; #1;
        check("R8 pin fan-out low", 64'(periph_in[7:4]), 64'h0);
        cfg_write(6'h20, 16'h0303);
        cfg_write(6'h21, 16'h0003);
        f_data = '0; f_data[3] = 1'b1; f_en = '0; f_en[3] = 1'b1;
        #1;
        check("R8 R5 code fan-out data", 64'(pin_out[2:0]), 64'h7);
        check("R8 R5 code fan-out enable", 64'(pin_oe[2:0]), 64'h7);
        check_all("R5 R8");

        // R5, R6: top valid code, reserved codes
        cfg_write(6'h22, 16'h1817);
        cfg_write(6'h23, 16'h3F00);
        f_data = '0; f_data[23] = 1'b1; f_en = '0; f_en[23] = 1'b1;
        gpio_lat = 10'h0; gpio_dir = 10'h3FF; #1;
        check("R5 highest code", 64'({pin_oe[4], pin_out[4]}), 64'h3);
        check("R6 code NC reserved", 64'({pin_oe[5], pin_out[5]}), 64'h0);
        check("R6 code 63 reserved", 64'({pin_oe[7], pin_out[7]}), 64'h0);
        check_all("R5 R6");

        // R9: analog pin silent and reads low on mapped inputs
        pin_in = '1; pin_analog = 10'h014; gpio_dir = '0; gpio_lat = '1; #1;
        check("R9 analog input low", 64'(periph_in[7:4]), 64'h0);
        check("R9 analog oe", 64'({pin_oe[4], pin_oe[2]}), 64'h0);
        check("R10 rdval", 64'(pin_rdval), 64'h3EB);
        check_all("R9 R10");

        // Random mix
        for (int it = 0; it < 400; it++) begin
            if ($urandom_range(0, 2) != 0)
                cfg_write(6'($urandom), 16'($urandom));
            @(negedge clk);
            pin_in     = NP'($urandom);
            pin_analog = NP'($urandom) & NP'($urandom) & NP'($urandom);
            gpio_lat   = NP'($urandom);
            gpio_dir   = NP'($urandom);
            f_data     = (NC-1)'($urandom);
            f_en       = (NC-1)'($urandom);
            check_all("R1 R4 R5 R6 R9 R10 random");
            check_read("R7 random readback", 6'($urandom));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule